// File: doc/BRIEF.md
# Clock Domain Source Selector and Divider

This block produces one domain clock from five incoming source clocks. A single 32-bit configuration word, written and read through a simple register port in the register clock domain, chooses the source and sets a divider. The divider's ratio is split into a wait count and a hold count. Source 0 is a slow real-time clock, source 1 is the main oscillator, and sources 2 to 4 are three PLL outputs.

A source change never produces a runt pulse. The old clock is gated off on its own falling edge. Only then is the new clock gated on, also on its own falling edge. Divider settings are staged in the register domain and handed across to the domain clock with a toggle handshake. The new settings are applied only at the end of a complete output period. Software starts either change with a write and then polls a self-clearing flag until the change has taken effect.

Two build-time variants exist. A narrow variant keeps only 3-bit wait and hold fields. A fixed variant always runs from source 4.

Top module: `domain_clock_gen`

## Requirements
- R1: After reset the word reads 0x0100_0001: select field = 1, bypass bit 24 = 1, wait and hold fields = 0, and both status flags (bit 3 and bit 25) = 0. Bits [31:26] and [15:4] always read 0. The fixed variant reads 0x0100_0004 after reset.
- R2: Bits [2:0] select the source. Code k in 0..4 drives the domain clock from src_clk[k]. A write with code 5, 6 or 7 leaves the select field unchanged and starts no switch.
- R3: A write whose code differs from the current one makes bit 3 (and sw_busy) read 1 from the next register cycle. The bit stays 1 until the new source is gated on, then returns to 0. Writing the current code does not set it. Select writes made while it is 1 are ignored.
- R4: With bypass off, the domain clock is high for wait+1 and low for hold+1 periods of the selected source. Wait is held in bits [19:16] and hold in bits [23:20], so the ratio is wait+hold+2.
- R5: With bypass (bit 24) on, the domain clock has the same waveform as the selected source.
- R6: A write with bit 25 = 1 stages bits 24 and [23:16] and makes bit 25 (and div_pending) read 1 from the next register cycle. The bit clears by itself once the staged values drive the output. Divider fields in a write with bit 25 = 0 are ignored, and so is a second request made while bit 25 reads 1.
- R7: A staged divider setting takes effect only at the end of a complete output period. Every output period therefore has the high and low lengths of either the old setting or the new one.
- R8: During a source switch no high or low pulse on the domain clock is shorter than the shortest half-period of the two sources involved.
- R9: In the narrow variant, bits 19 and 23 are stored and read as 0, so the ratio ranges from 2 to 16.
- R10: In the fixed variant the select field always reads 4, the domain clock runs from src_clk[4], and bit 3 never becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Synchronous active-low reset, held while all sources run |
| src_clk | input | 5 | Source clocks, index = select code |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Configuration and status readback |
| dom_clk | output | 1 | Generated domain clock |
| sw_busy | output | 1 | Source switch in progress (same as bit 3) |
| div_pending | output | 1 | Divider update not yet in effect (same as bit 25) |

## Verification
A source switch and a divider update can be in flight at the same time. A single write that carries a new select code and bit 25 starts both. The update's toggle then has to wait while the domain clock is stopped between the two gates, and it completes on the new source. The bench provokes this with one such write. It checks that both flags read 1 in the next register cycle and that both return to 0. It then checks that the measured high and low times equal the new source's period times the new wait+1 and hold+1.

// File: rtl/domain_clock_pkg.sv
`timescale 1ns/1ps
// Shared field positions and state type for the domain clock generator.
// The bit positions are part of the software-visible word and are fixed.
package domain_clock_pkg;
    localparam int SEL_LSB  = 0;
    localparam int BUSY_BIT = 3;
    localparam int WAIT_LSB = 16;
    localparam int HOLD_LSB = 20;
    localparam int BYP_BIT  = 24;
    localparam int UPD_BIT  = 25;

    // Source switch sequencer states
    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_DROP  = 2'd1,
        SW_RAISE = 2'd2
    } sw_state_e;
endpackage

// File: rtl/dcg_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer for a slowly changing level bus.
// Assumes each bit changes at most once per few destination cycles;
// resets synchronously (active low) to INIT in the destination domain.
module dcg_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= INIT;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcg_lane.sv
`timescale 1ns/1ps
// One source lane of the glitch-free selector: synchronizes the enable
// request into the source domain and updates the gate on the falling
// edge, so the gated clock only starts or stops while the source is low.
// Assumes rst_n is held for several source cycles.
module dcg_lane #(
    parameter int STAGES  = 2,
    parameter bit INIT_ON = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic gclk,
    output logic gate_on
);
    logic req_s;
    logic gate_q;

    dcg_sync #(.W(1), .STAGES(STAGES), .INIT(INIT_ON)) u_req_sync (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_s)
    );

    // Move the gate only while the source is low
    always_ff @(negedge src_clk) begin
        if (!rst_n) gate_q <= INIT_ON;
        else        gate_q <= req_s;
    end

    assign gclk    = src_clk & gate_q;
    assign gate_on = gate_q;
endmodule

// File: rtl/dcg_switch.sv
`timescale 1ns/1ps
// Register-domain sequencer for source changes. It drops the old lane's
// request, waits until every lane reports its gate off, raises the new
// lane's request and waits for its gate to report on. Assumes lane gate
// states arrive unsynchronized; they are synchronized here.
module dcg_switch
    import domain_clock_pkg::*;
#(
    parameter int NUM_SRC   = 5,
    parameter int SEL_W     = 3,
    parameter int RESET_SEL = 1,
    parameter bit FIXED_SRC = 1'b0,
    parameter int FIXED_IDX = 4,
    parameter int STAGES    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [SEL_W-1:0]   sel_code,
    input  logic [NUM_SRC-1:0] lane_on,
    output logic [NUM_SRC-1:0] lane_req,
    output logic [SEL_W-1:0]   sel_cur,
    output logic               busy
);
    localparam int                 INIT_SEL = FIXED_SRC ? FIXED_IDX : RESET_SEL;
    localparam logic [NUM_SRC-1:0] ONEHOT0  = NUM_SRC'(1) << INIT_SEL;
    localparam logic [SEL_W:0]     NUM_EXT  = (SEL_W+1)'(NUM_SRC);

    sw_state_e          state;
    logic [NUM_SRC-1:0] on_s;
    logic               code_ok;
    logic               accept;

    dcg_sync #(.W(NUM_SRC), .STAGES(STAGES), .INIT(ONEHOT0)) u_on_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lane_on),
        .q     (on_s)
    );

    // Fixed variant never accepts a select write
    generate
        if (FIXED_SRC) begin : g_fixed
            assign code_ok = 1'b0;
        end else begin : g_free
            assign code_ok = ({1'b0, sel_code} < NUM_EXT) && (sel_code != sel_cur);
        end
    endgenerate

    assign accept = sel_wr && code_ok && (state == SW_IDLE);

    // Three-step break-before-make sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SW_IDLE;
            sel_cur  <= SEL_W'(INIT_SEL);
            lane_req <= ONEHOT0;
        end else begin
            unique case (state)
                SW_IDLE: if (accept) begin
                    lane_req[sel_cur] <= 1'b0;
                    sel_cur           <= sel_code;
                    state             <= SW_DROP;
                end
                SW_DROP: if (on_s == '0) begin
                    lane_req[sel_cur] <= 1'b1;
                    state             <= SW_RAISE;
                end
                SW_RAISE: if (on_s[sel_cur]) begin
                    state <= SW_IDLE;
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    assign busy = (state != SW_IDLE);
endmodule

// File: rtl/dcg_divider.sv
`timescale 1ns/1ps
// Wait/hold divider running on the selected (muxed) source clock. The
// output is high for wait+1 and low for hold+1 cycles; bypass passes the
// source through. Staged settings are taken only at a period boundary,
// signalled by a toggle from the register domain and acknowledged by a
// toggle back. Assumes staged values are stable while a toggle is open.
module dcg_divider #(
    parameter int CNT_W  = 4,
    parameter int STAGES = 2
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             upd_tgl,
    input  logic [CNT_W-1:0] new_wait,
    input  logic [CNT_W-1:0] new_hold,
    input  logic             new_byp,
    output logic             dom_clk,
    output logic             ack_tgl
);
    logic             tgl_s;
    logic [CNT_W-1:0] wait_a, hold_a, cnt;
    logic             byp_a, div_q, ack_q;
    logic             at_end, take_new;

    dcg_sync #(.W(1), .STAGES(STAGES), .INIT(1'b0)) u_tgl_sync (
        .clk   (mclk),
        .rst_n (rst_n),
        .d     (upd_tgl),
        .q     (tgl_s)
    );

    assign at_end   = byp_a | (~div_q & (cnt == hold_a));
    assign take_new = at_end & (tgl_s != ack_q);

    // Load staged settings at a period boundary and acknowledge
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            wait_a <= '0;
            hold_a <= '0;
            byp_a  <= 1'b1;
            ack_q  <= 1'b0;
        end else if (take_new) begin
            wait_a <= new_wait;
            hold_a <= new_hold;
            byp_a  <= new_byp;
            ack_q  <= tgl_s;
        end
    end

    // Count the high and low phases of the divided clock
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (at_end) begin
            cnt   <= '0;
            div_q <= 1'b1;
        end else if (div_q && (cnt == wait_a)) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dom_clk = byp_a ? mclk : div_q;
    assign ack_tgl = ack_q;
endmodule

// File: rtl/domain_clock_gen.sv
`timescale 1ns/1ps
// Domain clock generator: glitch-free selection among NUM_SRC source
// clocks followed by a wait/hold divider with bypass. Holds the single
// configuration word, stages divider updates and reports switch and
// update progress. Assumes all sources run while rst_n is low.
module domain_clock_gen
    import domain_clock_pkg::*;
#(
    parameter int NUM_SRC     = 5,
    parameter int SEL_W       = 3,
    parameter int CNT_W       = 4,
    parameter int RESET_SEL   = 1,
    parameter bit FIXED_SRC   = 1'b0,
    parameter int FIXED_IDX   = 4,
    parameter bit NARROW      = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               wr_en,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    output logic               dom_clk,
    output logic               sw_busy,
    output logic               div_pending
);
    localparam int INIT_SEL = FIXED_SRC ? FIXED_IDX : RESET_SEL;

    logic [NUM_SRC-1:0] lane_req, lane_on, lane_gclk;
    logic [SEL_W-1:0]   sel_cur;
    logic               busy, mux_clk;
    logic [CNT_W-1:0]   stg_wait, stg_hold, wait_in, hold_in;
    logic               stg_byp, upd_tgl, ack_tgl, ack_s, pend;
    logic               unused_bits;

    assign unused_bits = ^{wr_data[31:26], wr_data[15:4], wr_data[BUSY_BIT]};

    dcg_switch #(
        .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .RESET_SEL(RESET_SEL),
        .FIXED_SRC(FIXED_SRC), .FIXED_IDX(FIXED_IDX), .STAGES(SYNC_STAGES)
    ) u_switch (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_wr   (wr_en),
        .sel_code (wr_data[SEL_LSB +: SEL_W]),
        .lane_on  (lane_on),
        .lane_req (lane_req),
        .sel_cur  (sel_cur),
        .busy     (busy)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
            dcg_lane #(.STAGES(SYNC_STAGES), .INIT_ON(i == INIT_SEL)) u_lane (
                .src_clk (src_clk[i]),
                .rst_n   (rst_n),
                .req     (lane_req[i]),
                .gclk    (lane_gclk[i]),
                .gate_on (lane_on[i])
            );
        end
    endgenerate

    // At most one lane gate is open, so OR-ing forms the selected clock
    assign mux_clk = |lane_gclk;

    // Narrow variant keeps only the lower bits of each count
    generate
        if (NARROW) begin : g_narrow
            assign wait_in = {1'b0, wr_data[WAIT_LSB +: CNT_W-1]};
            assign hold_in = {1'b0, wr_data[HOLD_LSB +: CNT_W-1]};
        end else begin : g_full
            assign wait_in = wr_data[WAIT_LSB +: CNT_W];
            assign hold_in = wr_data[HOLD_LSB +: CNT_W];
        end
    endgenerate

    dcg_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    assign pend = upd_tgl ^ ack_s;

    // Stage divider settings on an accepted update request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_wait <= '0;
            stg_hold <= '0;
            stg_byp  <= 1'b1;
            upd_tgl  <= 1'b0;
        end else if (wr_en && wr_data[UPD_BIT] && !pend) begin
            stg_wait <= wait_in;
            stg_hold <= hold_in;
            stg_byp  <= wr_data[BYP_BIT];
            upd_tgl  <= ~upd_tgl;
        end
    end

    dcg_divider #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_divider (
        .mclk     (mux_clk),
        .rst_n    (rst_n),
        .upd_tgl  (upd_tgl),
        .new_wait (stg_wait),
        .new_hold (stg_hold),
        .new_byp  (stg_byp),
        .dom_clk  (dom_clk),
        .ack_tgl  (ack_tgl)
    );

    // Assemble the readback word
    always_comb begin
        rd_data                       = '0;
        rd_data[SEL_LSB +: SEL_W]     = sel_cur;
        rd_data[BUSY_BIT]             = busy;
        rd_data[WAIT_LSB +: CNT_W]    = stg_wait;
        rd_data[HOLD_LSB +: CNT_W]    = stg_hold;
        rd_data[BYP_BIT]              = stg_byp;
        rd_data[UPD_BIT]              = pend;
    end

    assign sw_busy     = busy;
    assign div_pending = pend;
endmodule

// File: rtl/domain_clock_gen_chk.sv
`timescale 1ns/1ps
// Protocol checker for the configuration port of domain_clock_gen.
// Observes only the register-domain ports; bound into every instance.
module domain_clock_gen_chk #(
    parameter int NUM_SRC   = 5,
    parameter bit FIXED_SRC = 1'b0,
    parameter bit NARROW    = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data
);
    logic unused_chk;
    assign unused_chk = ^{wr_data[31:26], wr_data[24:3]};

    // R1: reserved bits never read as 1
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:26] == '0) && (rd_data[15:4] == '0));

    // R2: select field never holds an invalid code
    p_sel_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rd_data[2:0]) < NUM_SRC));

    // R3: a valid different code written while idle starts a switch
    p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!FIXED_SRC && wr_en && (32'(wr_data[2:0]) < NUM_SRC) &&
         (wr_data[2:0] != rd_data[2:0]) && !rd_data[3]) |=> rd_data[3]);

    // R3: select field does not move while a switch is running
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |=> $stable(rd_data[2:0]));

    // R6: an update request made while none is open raises the flag
    p_pend_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25] && !rd_data[25]) |=> rd_data[25]);

    // R6: divider fields change only on an accepted request
    p_fields_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[25] && !rd_data[25]) |=> $stable(rd_data[24:16]));

    // R9: narrow variant keeps the top count bits clear
    p_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        NARROW |-> (!rd_data[19] && !rd_data[23]));

    // R10: fixed variant stays on the last source and never switches
    p_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        FIXED_SRC |-> ((rd_data[2:0] == 3'd4) && !rd_data[3]));
endmodule

bind domain_clock_gen domain_clock_gen_chk #(
    .NUM_SRC(NUM_SRC), .FIXED_SRC(FIXED_SRC), .NARROW(NARROW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/domain_clock_gen_bench.sv
`timescale 1ns/1ps
// Bench: full instance plus a narrow fixed-source instance; pulse widths
// of the domain clock are measured in time and compared to arithmetic.
module domain_clock_gen_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0;
    logic [4:0] src;
    logic wr_en = 1'b0, tgt = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a, rd_b, rd_m;
    logic dom_a, dom_b, dom_m, busy_a, busy_b, pend_a, pend_b;
    int n_chk = 0, n_fail = 0;
    realtime sp [5] = '{40.0, 10.0, 6.0, 8.0, 14.0};

    always #2.5 clk = ~clk;
    always #20  s0 = ~s0;
    always #5   s1 = ~s1;
    always #3   s2 = ~s2;
    always #4   s3 = ~s3;
    always #7   s4 = ~s4;
    assign src = {s4, s3, s2, s1, s0};

    domain_clock_gen u_domain_clock_gen (
        .clk(clk), .rst_n(rst_n), .src_clk(src), .wr_en(wr_en & ~tgt),
        .wr_data(wr_data), .rd_data(rd_a), .dom_clk(dom_a),
        .sw_busy(busy_a), .div_pending(pend_a));

    domain_clock_gen #(.FIXED_SRC(1'b1), .NARROW(1'b1)) u_domain_clock_gen_nf (
        .clk(clk), .rst_n(rst_n), .src_clk(src), .wr_en(wr_en & tgt),
        .wr_data(wr_data), .rd_data(rd_b), .dom_clk(dom_b),
        .sw_busy(busy_b), .div_pending(pend_b));

    assign rd_m  = tgt ? rd_b : rd_a;
    assign dom_m = tgt ? dom_b : dom_a;

    // Minimum pulse width monitor used around source switches
    bit mon_on = 0, mon_have = 0;
    realtime mon_last = 0.0, mon_min = 1.0e9;
    always @(posedge dom_m or negedge dom_m) begin
        if (mon_on) begin
            if (mon_have && ($realtime - mon_last < mon_min)) mon_min = $realtime - mon_last;
            mon_have = 1;
        end
        mon_last = $realtime;
    end

    function automatic bit feq(input realtime a, input realtime b);
        return (a - b < 0.001) && (b - a < 0.001);
    endfunction

    function automatic logic [31:0] cfg(input int sel, input bit upd, input bit byp,
                                        input int w, input int h);
        return 32'(sel) | (32'(w) << 16) | (32'(h) << 20) | (32'(byp) << 24) | (32'(upd) << 25);
    endfunction

    task automatic chk_r(input bit ok, input string req, input string what,
                         input realtime act, input realtime exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    task automatic chk_h(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((rd_m[3] || rd_m[25]) && n < 6000) begin @(negedge clk); n++; end
        chk_r(n < 6000, req, "flags never cleared", n, 6000);
    endtask

    task automatic measure(output realtime hi, output realtime lo);
        realtime t0, t1, t2;
        @(posedge dom_m); @(posedge dom_m); t0 = $realtime;
        @(negedge dom_m); t1 = $realtime;
        @(posedge dom_m); t2 = $realtime;
        hi = t1 - t0; lo = t2 - t1;
    endtask

    initial begin
        #950000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        realtime hi, lo;
        int codes [4] = '{0, 3, 4, 2};
        repeat (20) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of both variants
        chk_h("R1", "reset word", rd_a, 32'h0100_0001);
        chk_h("R1", "fixed reset word", rd_b, 32'h0100_0004);
        chk_h("R1", "status pins", {28'd0, busy_a, pend_a, busy_b, pend_b}, 32'd0);

        // R5: bypass after reset follows the source waveform
        measure(hi, lo);
        chk_r(feq(hi, 5.0) && feq(lo, 5.0), "R5", "bypass src1 high", hi, 5.0);

        // R6: request flag rises and clears, fields staged
        wr(cfg(1, 1, 0, 2, 1));
        chk_h("R6", "pending after request", {31'd0, rd_m[25]}, 32'd1);
        wait_idle("R6");
        chk_h("R6", "word after update", rd_m, 32'h0012_0001);
        measure(hi, lo);
        chk_r(feq(hi, 30.0) && feq(lo, 20.0), "R4", "w2 h1 high", hi, 30.0);

        // R6: divider fields without the request bit are ignored
        wr(cfg(1, 0, 1, 5, 5));
        chk_h("R6", "no-request write", rd_m, 32'h0012_0001);
        measure(hi, lo);
        chk_r(feq(hi, 30.0) && feq(lo, 20.0), "R6", "output unchanged", hi, 30.0);

        // R4: sweep of every wait/hold pair on source 1
        for (int w = 0; w < 16; w++) begin
            for (int h = 0; h < 16; h++) begin
                wr(cfg(1, 1, 0, w, h));
                wait_idle("R4");
                measure(hi, lo);
                chk_r(feq(hi, (w + 1) * 10.0), "R4", "high time", hi, (w + 1) * 10.0);
                chk_r(feq(lo, (h + 1) * 10.0), "R4", "low time", lo, (h + 1) * 10.0);
            end
        end

        // R6: second request while one is open is ignored
        wr(cfg(1, 1, 0, 1, 1));
        wr(cfg(1, 1, 0, 7, 7));
        wait_idle("R6");
        chk_h("R6", "first request kept", rd_m, 32'h0011_0001);

        // R7: change from 2+2 to 6+6 only at whole periods
        begin
            bit all_ok = 1'b1;
            realtime ta, tb, tc, hi_last = 0.0;
            wr(cfg(1, 1, 0, 5, 5));
            @(posedge dom_m);
            for (int p = 0; p < 6; p++) begin
                ta = $realtime; @(negedge dom_m); tb = $realtime; @(posedge dom_m); tc = $realtime;
                if (!(feq(tb - ta, tc - tb) && (feq(tb - ta, 20.0) || feq(tb - ta, 60.0))))
                    all_ok = 1'b0;
                hi_last = tb - ta;
            end
            chk_r(all_ok, "R7", "every period whole", hi_last, 60.0);
            chk_r(feq(hi_last, 60.0), "R7", "new setting reached", hi_last, 60.0);
        end

        // R2 R3 R8: switch through sources in bypass
        wr(cfg(1, 1, 1, 0, 0));
        wait_idle("R5");
        for (int k = 0; k < 4; k++) begin
            mon_have = 0; mon_min = 1.0e9; mon_on = 1;
            wr(cfg(codes[k], 0, 0, 0, 0));
            chk_h("R3", "busy after select write", {31'd0, rd_m[3]}, 32'd1);
            wait_idle("R3");
            @(posedge dom_m); @(posedge dom_m);
            mon_on = 0;
            chk_r(mon_min > 2.999, "R8", "shortest pulse in switch", mon_min, 3.0);
            chk_h("R2", "select readback", 32'(rd_m[2:0]), 32'(codes[k]));
            measure(hi, lo);
            chk_r(feq(hi, sp[codes[k]] / 2) && feq(lo, sp[codes[k]] / 2), "R2",
                  "source half period", hi, sp[codes[k]] / 2);
        end

        // R3: writing the current code starts nothing
        wr(cfg(2, 0, 0, 0, 0));
        chk_h("R3", "same code busy", {31'd0, rd_m[3]}, 32'd0);

        // R3: a select write during a switch is ignored
        wr(cfg(4, 0, 0, 0, 0));
        wr(cfg(0, 0, 0, 0, 0));
        wait_idle("R3");
        chk_h("R3", "write during busy ignored", 32'(rd_m[2:0]), 32'd4);
        measure(hi, lo);
        chk_r(feq(hi, 7.0), "R3", "runs from source 4", hi, 7.0);

        // R2: invalid codes leave the selection untouched
        for (int c = 5; c < 8; c++) begin
            wr(cfg(c, 0, 0, 0, 0));
            chk_h("R2", "invalid code ignored", rd_m & 32'hF, 32'd4);
        end

        // R3 and R6 together: new source and new divisor in one write
        wr(cfg(3, 1, 0, 2, 2));
        chk_h("R3", "busy in joint write", {31'd0, busy_a}, 32'd1);
        chk_h("R6", "pending in joint write", {31'd0, pend_a}, 32'd1);
        wait_idle("R6");
        measure(hi, lo);
        chk_r(feq(hi, 24.0) && feq(lo, 24.0), "R4", "joint result src3 w2 h2", hi, 24.0);

        // R9 R10: narrow fixed-source variant
        tgt = 1'b1;
        wr(cfg(4, 1, 0, 15, 15));
        wait_idle("R9");
        chk_h("R9", "top count bits dropped", rd_m, 32'h0077_0004);
        measure(hi, lo);
        chk_r(feq(hi, 112.0) && feq(lo, 112.0), "R9", "ratio 16 on source 4", hi, 112.0);
        wr(cfg(1, 0, 0, 0, 0));
        chk_h("R10", "select write ignored", rd_m & 32'hF, 32'd4);
        wr(cfg(4, 1, 0, 3, 6));
        wait_idle("R9");
        measure(hi, lo);
        chk_r(feq(hi, 56.0) && feq(lo, 98.0), "R10", "still on source 4", lo, 98.0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule